// File: doc/BRIEF.md
# Three-Operand Adder with Carry Result

This unit adds three 64-bit source operands in one pass and returns one of two results, chosen by a one-bit operation select. In sum mode the result is the low 64 bits of the three-way sum. In carry mode the result is the part of that same sum that lies above bit 63, returned zero-extended as an ordinary 64-bit data word. The datapath stays 64 bits wide. There is no flags register and no overflow output.

Software builds wide additions one 64-bit limb at a time. For each limb it issues the carry operation and the sum operation on the same two limbs. The third operand is the carry word from the limb below, or zero for the least significant limb. The carry word of the top limb becomes the extra top bit of the wide result. A 256-bit add therefore takes four limb steps. Because no hidden flags state is involved, the two operations of a limb are independent and can be issued to two copies of the unit in the same cycle.

The result is registered. It appears one cycle after the operands are presented together with the input valid strobe.

Top module: `tri_add_unit`

## Requirements
- R1: When valid_i is high with op_i = 0 (sum mode), result_o one cycle later equals (opa_i + opb_i + opc_i) modulo 2^64.
- R2: When valid_i is high with op_i = 1 (carry mode), result_o one cycle later holds floor((opa_i + opb_i + opc_i) / 2^64) in bits [1:0], and bits [63:2] are zero.
- R3: The carry-mode value never exceeds 2. Three all-ones operands give a carry of 2 and a sum of 0xFFFF_FFFF_FFFF_FFFD.
- R4: With opc_i equal to zero, the carry-mode value is 0 or 1, so a chained carry fed back in as a third operand is at most 1.
- R5: valid_o equals valid_i delayed by exactly one clock cycle.
- R6: In a cycle where valid_i is low, op_i and the operands are ignored, and result_o keeps its previous value.
- R7: While rst_ni is low, valid_o and result_o are zero.
- R8: Four chained limb steps, with zero as the third operand of the lowest limb, produce the exact 257-bit sum of two 256-bit numbers. The top carry word supplies bit 256. This includes all-ones operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and op_i are valid this cycle |
| op_i | input | 1 | 0 = sum result, 1 = carry result |
| opa_i | input | 64 | First source operand |
| opb_i | input | 64 | Second source operand |
| opc_i | input | 64 | Third source operand (carry-in word when chaining) |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 64 | Registered sum or zero-extended carry |

## Verification
Both the sum result and the carry result pass through exactly one register, so each is due at the first rising edge after valid_i is high. The bench drives valid_i and the operands on a falling edge and reads result_o and valid_o on the next falling edge, half a period after the capturing edge. It then drops valid_i before the next edge, so a read never mixes two operations. The hold check changes the operation and the operands with valid_i low, then reads one full cycle later to confirm that nothing was captured.

// File: rtl/tri_add_pkg.sv
package tri_add_pkg;
  typedef enum logic {
    OP_SUM   = 1'b0,
    OP_CARRY = 1'b1
  } tri_op_e;
endpackage

// File: rtl/tri_add_csa.sv
// 3:2 compressor: per-bit sum vector and carry vector (carry weight 2^(i+1)).
module tri_add_csa #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign s_o[i] = x_i[i] ^ y_i[i] ^ z_i[i];
    assign c_o[i] = (x_i[i] & y_i[i]) | (x_i[i] & z_i[i]) | (y_i[i] & z_i[i]);
  end
endmodule

// File: rtl/tri_add_cpa.sv
// Carry-propagate stage: merges CSA vectors into the widened total.
module tri_add_cpa #(
  parameter int unsigned W  = 64,
  parameter int unsigned CW = 2
) (
  input  logic [W-1:0]    s_i,
  input  logic [W-1:0]    c_i,
  output logic [W+CW-1:0] total_o
);
  logic [W+CW-1:0] s_ext;
  logic [W+CW-1:0] c_ext;

  assign s_ext   = {{CW{1'b0}}, s_i};
  assign c_ext   = {{(CW-1){1'b0}}, c_i, 1'b0};
  assign total_o = s_ext + c_ext;
endmodule

// File: rtl/tri_add_sel.sv
module tri_add_sel
  import tri_add_pkg::*;
#(
  parameter int unsigned W  = 64,
  parameter int unsigned CW = 2
) (
  input  tri_op_e         op_i,
  input  logic [W+CW-1:0] total_i,
  output logic [W-1:0]    res_o
);
  always_comb begin
    if (op_i == OP_CARRY) res_o = {{(W-CW){1'b0}}, total_i[W+CW-1:W]};
    else                  res_o = total_i[W-1:0];
  end
endmodule

// File: rtl/tri_add_unit.sv
module tri_add_unit
  import tri_add_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [DATA_W-1:0] opc_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int unsigned N_OPS   = 3;
  localparam int unsigned CARRY_W = $clog2(N_OPS);

  logic [DATA_W-1:0]         csa_s;
  logic [DATA_W-1:0]         csa_c;
  logic [DATA_W+CARRY_W-1:0] total;
  logic [DATA_W-1:0]         res_d;
  logic [DATA_W-1:0]         res_q;
  logic                      valid_q;

  tri_add_csa #(.W(DATA_W)) i_csa (
    .x_i(opa_i), .y_i(opb_i), .z_i(opc_i), .s_o(csa_s), .c_o(csa_c)
  );

  tri_add_cpa #(.W(DATA_W), .CW(CARRY_W)) i_cpa (
    .s_i(csa_s), .c_i(csa_c), .total_o(total)
  );

  tri_add_sel #(.W(DATA_W), .CW(CARRY_W)) i_sel (
    .op_i(tri_op_e'(op_i)), .total_i(total), .res_o(res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) res_q <= res_d;
    end
  end

  assign valid_o  = valid_q;
  assign result_o = res_q;

  p_valid_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  p_carry_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_CARRY) |=> result_o[DATA_W-1:CARRY_W] == '0);
  p_carry_max_two_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_CARRY) |=> result_o[CARRY_W-1:0] != 2'b11);
  p_carry_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_CARRY && opc_i == '0) |=> !result_o[1]);
  p_sum_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_SUM && opa_i == '0 && opb_i == '0 && opc_i == '0)
    |=> result_o == '0);
endmodule

// File: tb/test_tri_add_unit.sv
`timescale 1ns/1ps
module test_tri_add_unit;
  localparam int NV = 8;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] VA [NV] = '{64'h0, ONES, ONES, ONES,
    64'h8000_0000_0000_0000, 64'h0123_4567_89AB_CDEF, 64'h5555_5555_5555_5555, ONES};
  localparam logic [63:0] VB [NV] = '{64'h0, 64'h1, ONES, ONES,
    64'h8000_0000_0000_0000, 64'hFEDC_BA98_7654_3210, 64'hAAAA_AAAA_AAAA_AAAA, 64'h0};
  localparam logic [63:0] VC [NV] = '{64'h0, 64'h0, ONES, 64'h0,
    64'h8000_0000_0000_0000, 64'h1, 64'h2, ONES};
  localparam logic [1:0]  VK [NV] = '{2'd0, 2'd1, 2'd2, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        op_i = 1'b0;
  logic [63:0] opa_i = '0, opb_i = '0, opc_i = '0;
  logic        valid_o;
  logic [63:0] result_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  tri_add_unit i_tri_add_unit (
    .clk_i, .rst_ni, .valid_i, .op_i, .opa_i, .opb_i, .opc_i, .valid_o, .result_o
  );

  task automatic chk(input string req, input logic [256:0] act, input logic [256:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // entered at a falling edge; returns at the next falling edge
  task automatic run_op(input logic op, input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] c, output logic [63:0] r, output logic v);
    valid_i = 1'b1; op_i = op; opa_i = a; opb_i = b; opc_i = c;
    @(negedge clk_i);
    r = result_o; v = valid_o;
    valid_i = 1'b0;
  endtask

  task automatic add256(input logic [255:0] a, input logic [255:0] b);
    logic [63:0]  cin, cnext, s, r;
    logic         v;
    logic [255:0] sum;
    logic [256:0] expv;
    cin = '0;
    for (int k = 0; k < 4; k++) begin
      run_op(1'b1, a[64*k +: 64], b[64*k +: 64], cin, cnext, v);
      chk("R4 chained carry <= 1", {255'b0, cnext[63:1] != 0}, 257'd0);
      run_op(1'b0, a[64*k +: 64], b[64*k +: 64], cin, s, v);
      sum[64*k +: 64] = s;
      cin = cnext;
    end
    expv = {1'b0, a} + {1'b0, b};
    r = cin;
    chk("R8 256-bit chain", {r[0], sum}, expv);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] r, hold;
    logic        v;
    logic [65:0] full;

    // R7: reset state
    repeat (2) @(negedge clk_i);
    valid_i = 1'b1; op_i = 1'b1; opa_i = ONES; opb_i = ONES; opc_i = ONES;
    @(negedge clk_i);
    chk("R7 reset valid_o", {256'b0, valid_o}, 257'd0);
    chk("R7 reset result_o", {193'b0, result_o}, 257'd0);
    valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);

    // vector table: both modes per entry
    for (int i = 0; i < NV; i++) begin
      full = {2'b0, VA[i]} + {2'b0, VB[i]} + {2'b0, VC[i]};
      run_op(1'b0, VA[i], VB[i], VC[i], r, v);
      chk("R1 sum mode", {193'b0, r}, {193'b0, full[63:0]});
      chk("R5 valid after sum", {256'b0, v}, 257'd1);
      run_op(1'b1, VA[i], VB[i], VC[i], r, v);
      chk("R2 carry mode", {193'b0, r}, {255'b0, VK[i]});
      chk("R2 carry from reference", {193'b0, r}, {255'b0, full[65:64]});
      if (i == 2) chk("R3 all-ones carry is 2", {193'b0, r}, 257'd2);
    end

    // R3: sum side of the all-ones case
    run_op(1'b0, ONES, ONES, ONES, r, v);
    chk("R3 all-ones sum", {193'b0, r}, {193'b0, 64'hFFFF_FFFF_FFFF_FFFD});

    // R5 / R6: idle cycle, inputs toggled while valid_i low
    hold = r;
    op_i = 1'b1; opa_i = 64'h1234; opb_i = 64'h5678; opc_i = 64'h9;
    @(negedge clk_i);
    chk("R5 valid_o low when idle", {256'b0, valid_o}, 257'd0);
    chk("R6 result held while idle", {193'b0, result_o}, {193'b0, hold});
    op_i = 1'b0; opa_i = ONES;
    @(negedge clk_i);
    chk("R6 result still held", {193'b0, result_o}, {193'b0, hold});

    // R4: zero third operand
    run_op(1'b1, ONES, ONES, 64'h0, r, v);
    chk("R4 carry with opc zero", {193'b0, r}, 257'd1);

    // R8: chained 256-bit additions
    add256({4{ONES}}, {4{ONES}});
    add256({4{ONES}}, 256'd1);
    add256(256'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210_DEAD_BEEF_0000_FFFF_8000_0000_0000_0001,
           256'hFEDC_BA98_7654_3210_0123_4567_89AB_CDEF_2152_4110_FFFF_0000_8000_0000_0000_0000);
    add256(256'd0, 256'd0);
    add256({2{128'h8000_0000_0000_0000_7FFF_FFFF_FFFF_FFFF}},
           {2{128'h8000_0000_0000_0000_0000_0000_0000_0001}});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule